// File: doc/BRIEF.md
# Peripheral-Shared Parallel I/O Port

A parallel port of `N` pins that a processor reaches through a small synchronous register bus. Each pin has a direction bit, an output latch bit and a pin-level read path. A per-pin multiplexer decides who owns the pad's output data and output enable. The port owns the pad by default. An attached peripheral takes the pad over when it is enabled and actively driving that pin.

There are three register addresses: direction, latch and pin level. A write to either the latch or the pin-level address lands in the latch. A read of the pin-level address returns the pad inputs after a two-flop synchronizer. A read of the latch returns the stored latch value.

Two parameter masks shape the pins. `IMPL_MASK` marks the pins that exist on a given device; absent pins read as zero and never drive. `OVR_MASK` marks the pins whose peripheral can drive an output; pins whose only other function is an input stay under port control at all times.

Top module: `pio_port`

## Requirements
- R1: On reset every implemented direction bit is 1, so every pin is an input. The latch clears to 0, and no pad output enable is asserted.
- R2: Address 0 is the direction register. A write there sets the direction bits. On a port-owned implemented pin, `pad_oe` equals the inverse of its direction bit: direction 0 means output.
- R3: Address 1 is the latch. A write there stores the data, and a read of address 1 returns the stored latch, not the pin levels. On a port-owned implemented pin, `pad_out` equals its latch bit.
- R4: A write to address 2 (pin level) updates the latch exactly as a write to address 1 does.
- R5: A read of address 2 returns the `pad_in` value sampled two rising clock edges earlier, ANDed with `IMPL_MASK`.
- R6: On an implemented pin with its `OVR_MASK` bit set, if `per_en` and `per_drive` are both 1, `pad_oe` is 1 and `pad_out` follows `per_dout`. The pin level stays readable through address 2.
- R7: If `per_en` is 1 but `per_drive` is 0, the pin stays under direction and latch control.
- R8: Pins with a 0 in `IMPL_MASK` read as 0 at all three addresses. Writes to them have no effect, and their `pad_oe` and `pad_out` are always 0.
- R9: Pins with a 0 in `OVR_MASK` are never taken over by the peripheral, whatever `per_en` and `per_drive` say.
- R10: Address 3 reads as zero, and a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 direction, 1 latch, 2 pin level, 3 unused |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | N | Write data |
| bus_rdata | output | N | Read data for the register at `bus_addr`, combinational |
| pad_in | input | N | Pad input levels |
| pad_out | output | N | Pad output data |
| pad_oe | output | N | Pad output enable, 1 = drive |
| per_en | input | N | Per-pin peripheral enable |
| per_drive | input | N | Per-pin peripheral drive request |
| per_dout | input | N | Per-pin peripheral output data |

## Verification
A register write takes effect at the rising edge that samples it. The new value therefore shows on `bus_rdata`, `pad_out` and `pad_oe` one cycle later. A change on `pad_in` shows at address 2 only after two further rising edges. Changes on the peripheral inputs reach `pad_out` and `pad_oe` in the same cycle. The bench keeps a behavioural model that it advances at each rising edge, using the inputs held through that edge. It compares all outputs one time unit later, before it drives any new input, so each result is checked in exactly the cycle it is due.

// File: rtl/pio_port.sv
module pio_port #(
  parameter int          N         = 8,
  parameter logic [N-1:0] IMPL_MASK = 8'h7F,
  parameter logic [N-1:0] OVR_MASK  = 8'hEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic [N-1:0] bus_wdata,
  output logic [N-1:0] bus_rdata,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe,
  input  logic [N-1:0] per_en,
  input  logic [N-1:0] per_drive,
  input  logic [N-1:0] per_dout
);
  localparam logic [1:0] A_DIR = 2'd0;
  localparam logic [1:0] A_LAT = 2'd1;
  localparam logic [1:0] A_PIN = 2'd2;

  logic [N-1:0] dir_q, lat_q, sync1_q, sync2_q;

  wire wr_dir = bus_wr && (bus_addr == A_DIR);
  wire wr_lat = bus_wr && ((bus_addr == A_LAT) || (bus_addr == A_PIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= IMPL_MASK;
      lat_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      if (wr_dir) dir_q <= bus_wdata & IMPL_MASK;
      if (wr_lat) lat_q <= bus_wdata & IMPL_MASK;
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_DIR:   bus_rdata = dir_q;
      A_LAT:   bus_rdata = lat_q;
      A_PIN:   bus_rdata = sync2_q & IMPL_MASK;
      default: bus_rdata = '0;
    endcase
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    if (!IMPL_MASK[i]) begin : g_absent
      assign pad_out[i] = 1'b0;
      assign pad_oe[i]  = 1'b0;
    end else if (OVR_MASK[i]) begin : g_shared
      wire own = per_en[i] & per_drive[i];
      assign pad_out[i] = own ? per_dout[i] : lat_q[i];
      assign pad_oe[i]  = own | ~dir_q[i];
    end else begin : g_dedicated
      assign pad_out[i] = lat_q[i];
      assign pad_oe[i]  = ~dir_q[i];
    end
  end
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
  parameter int          N         = 8,
  parameter logic [N-1:0] IMPL_MASK = 8'h7F,
  parameter logic [N-1:0] OVR_MASK  = 8'hEF
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   bus_addr,
  input logic         bus_wr,
  input logic [N-1:0] bus_wdata,
  input logic [N-1:0] bus_rdata,
  input logic [N-1:0] pad_in,
  input logic [N-1:0] pad_out,
  input logic [N-1:0] pad_oe,
  input logic [N-1:0] per_en,
  input logic [N-1:0] per_drive,
  input logic [N-1:0] per_dout
);
  logic [1:0] seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= '0;
    else if (seen != 2'd3) seen <= seen + 2'd1;

  wire [N-1:0] taken = per_en & per_drive & OVR_MASK & IMPL_MASK;

  assert_reset_dir_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && bus_addr == 2'd0) |-> bus_rdata == IMPL_MASK);
  assert_reset_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe & ~taken) == '0);
  assert_pinwrite_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 2'd1 && $past(bus_wr) && ($past(bus_addr) == 2'd1 || $past(bus_addr) == 2'd2))
      |-> ((pad_out ^ $past(bus_wdata)) & IMPL_MASK & ~taken) == '0);
  assert_pin_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 2'd2 && bus_addr == 2'd2) |-> bus_rdata == ($past(pad_in, 2) & IMPL_MASK));
  assert_periph_own_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & taken) == taken) && (((pad_out ^ per_dout) & taken) == '0));
  assert_absent_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out | bus_rdata) & ~IMPL_MASK) == '0);
  assert_unused_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 2'd3 |-> bus_rdata == '0);
endmodule

bind pio_port pio_port_chk #(.N(N), .IMPL_MASK(IMPL_MASK), .OVR_MASK(OVR_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .per_en(per_en),
  .per_drive(per_drive), .per_dout(per_dout)
);

// File: tb/pio_port_tb.sv
module pio_port_tb;
  localparam int N = 8;
  localparam logic [N-1:0] IMPL = 8'h7F;
  localparam logic [N-1:0] OVR  = 8'hEF;

  logic clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0;
  logic [N-1:0] bus_wdata = 0, pad_in = 0, per_en = 0, per_drive = 0, per_dout = 0;
  logic [N-1:0] bus_rdata, pad_out, pad_oe;

  pio_port #(.N(N), .IMPL_MASK(IMPL), .OVR_MASK(OVR)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .per_en(per_en),
    .per_drive(per_drive), .per_dout(per_dout));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  string tag = "R1";
  logic [N-1:0] m_dir, m_lat;
  logic [N-1:0] hist[$];

  function automatic logic [N-1:0] exp_rd();
    case (bus_addr)
      2'd0: return m_dir;
      2'd1: return m_lat;
      2'd2: return hist[0] & IMPL;
      default: return '0;
    endcase
  endfunction

  function automatic logic [N-1:0] exp_out();
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++)
      if (IMPL[i]) r[i] = (OVR[i] && per_en[i] && per_drive[i]) ? per_dout[i] : m_lat[i];
    return r;
  endfunction

  function automatic logic [N-1:0] exp_oe();
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++)
      if (IMPL[i]) r[i] = (OVR[i] && per_en[i] && per_drive[i]) ? 1'b1 : !m_dir[i];
    return r;
  endfunction

  task automatic chk(string req, string what, logic [N-1:0] act, logic [N-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic compare();
    chk(tag, "rdata", bus_rdata, exp_rd());
    chk(tag, "pad_out", pad_out, exp_out());
    chk(tag, "pad_oe", pad_oe, exp_oe());
  endtask

  task automatic step();
    @(posedge clk);
    if (bus_wr && bus_addr == 2'd0) m_dir = bus_wdata & IMPL;
    if (bus_wr && (bus_addr == 2'd1 || bus_addr == 2'd2)) m_lat = bus_wdata & IMPL;
    hist.push_back(pad_in);
    void'(hist.pop_front());
    #1 compare();
  endtask

  task automatic wr(logic [1:0] a, logic [N-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; step();
    bus_wr = 0; step();
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_dir = IMPL; m_lat = '0; hist = '{'0, '0};
    #23 rst_n = 1;
    tag = "R1";
    #1 chk("R1", "reset dir", bus_rdata, IMPL);
    chk("R1", "reset oe", pad_oe, '0);
    bus_addr = 1; #1 chk("R1", "reset lat", bus_rdata, '0);
    step(); step();

    tag = "R2"; wr(2'd0, 8'hF0); bus_addr = 0; step();
    chk("R2", "oe low nibble", pad_oe, 8'h0F);
    tag = "R3"; pad_in = 8'h00; wr(2'd1, 8'h5A); bus_addr = 1; step();
    chk("R3", "latch readback", bus_rdata, 8'h5A);
    chk("R3", "pad_out", pad_out, 8'h5A);
    tag = "R4"; wr(2'd2, 8'h33); bus_addr = 1; step();
    chk("R4", "pin write to latch", bus_rdata, 8'h33);

    tag = "R5"; bus_addr = 2;
    foreach (hist[k]) hist[k] = hist[k];
    pad_in = 8'hC3; step(); step(); step();
    chk("R5", "pin read", bus_rdata, 8'h43);
    pad_in = 8'h1C; step();
    chk("R5", "one edge old", bus_rdata, 8'h43);
    step();
    chk("R5", "two edges", bus_rdata, 8'h1C);
    for (int k = 0; k < 20; k++) begin pad_in = 8'(k * 37 + 11); step(); end

    tag = "R6"; per_en = 8'hFF; per_drive = 8'h0F; per_dout = 8'h0A; step();
    chk("R6", "override oe", pad_oe & 8'h0F, 8'h0F);
    chk("R6", "override out", pad_out & 8'h0F, 8'h0A);
    pad_in = 8'h05; step(); step(); bus_addr = 2; #1
    chk("R6", "pin still readable", bus_rdata, 8'h05);

    tag = "R7"; per_drive = 8'h00; step();
    chk("R7", "not driving", pad_oe, 8'h0F);
    chk("R7", "latch out", pad_out, 8'h33);

    tag = "R9"; wr(2'd0, 8'h7F); per_drive = 8'h10; per_dout = 8'h10; step();
    chk("R9", "input-only pin no oe", pad_oe, 8'h00);
    per_drive = 8'h20; per_dout = 8'h20; step();
    chk("R9", "shared pin oe", pad_oe, 8'h20);
    per_en = 0; per_drive = 0; per_dout = 0;

    tag = "R8"; wr(2'd0, 8'h00); wr(2'd1, 8'hFF); bus_addr = 1; step();
    chk("R8", "absent latch bit", bus_rdata, 8'h7F);
    chk("R8", "absent oe", pad_oe, 8'h7F);
    pad_in = 8'hFF; step(); step(); bus_addr = 2; step();
    chk("R8", "absent pin", bus_rdata, 8'h7F);
    bus_addr = 0; #1 chk("R8", "absent dir", bus_rdata, 8'h00);

    tag = "R10"; wr(2'd3, 8'hAA); bus_addr = 3; step();
    chk("R10", "unused read", bus_rdata, 8'h00);
    bus_addr = 1; #1 chk("R10", "latch untouched", bus_rdata, 8'h7F);
    bus_addr = 0; #1 chk("R10", "dir untouched", bus_rdata, 8'h00);
    step();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule